// File: doc/BRIEF.md
# Suspend Modulation Duty Generator

This block throttles a processor core by driving its active-low suspend input. Once enabled, the output alternates between an idle window, with suspend asserted so the core stops, and a run window, with suspend released. Each window's length is an 8-bit count of fixed ticks, nominally 32 us each. The core's effective clock is therefore the full clock scaled by run / (run + idle). A tick prescaler derives the tick from the system clock, and a second stage derives a millisecond pulse from the tick.

Two speedup timers suspend the throttling for a programmed number of milliseconds after an interrupt event or a video event. Each timer has its own enable bit and reload count. Software programs everything through a byte-wide register port. The port has one write strobe and a combinational read-back of the addressed byte. New window lengths are adopted only at a period boundary, so a window is never cut short or stretched by a write.

Top module: `susp_mod_gen`

## Requirements
- R1: After reset, `susp_n` is 1 and every mapped register reads 0x00.
- R2: The registers are mapped as follows: idle count at 0x94, run count at 0x95, suspend config at 0x96, power-management control at 0x80, interrupt speedup count at 0x8C, video speedup count at 0x8D. Each one reads back the byte last written. A write to any other address changes nothing, and reading any other address returns 0x00.
- R3: Modulation is active when bit 0 of 0x80 and bit 0 of 0x96 are both set and no speedup timer is running. While it is active, `susp_n` repeats a low phase of OFF×TICK_DIV clocks and then a high phase of ON×TICK_DIV clocks. OFF is the value at 0x94 and ON is the value at 0x95. `susp_n` only falls in the cycle after a tick.
- R4: While bit 0 of 0x96 is clear, `susp_n` stays 1.
- R5: While bit 0 of 0x80 (the global gate) is clear, `susp_n` stays 1 whatever the other bits hold.
- R6: An idle count of 0 keeps `susp_n` at 1 while modulation is active.
- R7: A run count of 0 with a nonzero idle count keeps `susp_n` at 0 while modulation is active.
- R8: Window counts written in the middle of a period take effect only at the next period boundary. The current idle window and the following run window keep their old lengths.
- R9: When bit 3 of 0x80 is set, an `irq_event` pulse releases `susp_n` from the next cycle. It stays released for between N-1 and N milliseconds (N is the value at 0x8C), plus up to one tick before modulation resumes. With bit 3 clear, the pulse has no effect.
- R10: Bit 4 of 0x80 enables the same behaviour for `video_event`, using the count N at 0x8D.
- R11: An event arriving while its timer is running reloads the timer to its full count.
- R12: Clearing the enable bit or the global gate releases `susp_n` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register byte address |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the addressed register |
| irq_event | input | 1 | One-cycle interrupt event pulse |
| video_event | input | 1 | One-cycle video event pulse |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
The duty cycle is measured on several idle/run pairs: a balanced pair, the shortest 1/1 pair, an idle-heavy pair, and both extremes that involve a count of 255. Together these separate a swapped idle/run mapping, off-by-one window lengths and truncated counters. The degenerate pairs with one count at zero show whether the zero-count cases are handled or fall into a 256-tick wrap. A write made mid-window, followed by timing of the next two periods, shows whether new counts are latched at the boundary or adopted immediately. The speedup tests compare a single event, a repeated event and an event with its enable clear. This tells a reloading timer apart from one that ignores a second event, and a gated event apart from one that always fires.

// File: rtl/susp_pkg.sv
package susp_pkg;

    localparam int CNT_W = 8;

    localparam logic [7:0] A_IDLE_CNT = 8'h94;
    localparam logic [7:0] A_RUN_CNT  = 8'h95;
    localparam logic [7:0] A_SUS_CFG  = 8'h96;
    localparam logic [7:0] A_PM_CTL   = 8'h80;
    localparam logic [7:0] A_IRQ_CNT  = 8'h8C;
    localparam logic [7:0] A_VID_CNT  = 8'h8D;

    localparam int B_MOD_EN = 0;
    localparam int B_GATE   = 0;
    localparam int B_IRQ_EN = 3;
    localparam int B_VID_EN = 4;

    localparam int N_SPD    = 2;
    localparam int SPD_IRQ  = 0;
    localparam int SPD_VID  = 1;

    typedef enum logic {PH_RUN = 1'b0, PH_IDLE = 1'b1} phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] idle_cnt;
        logic [CNT_W-1:0] run_cnt;
        logic             mod_en;
        logic             gate;
        logic             irq_en;
        logic             vid_en;
        logic [CNT_W-1:0] irq_cnt;
        logic [CNT_W-1:0] vid_cnt;
    } ctrl_t;

endpackage

// File: rtl/susp_tick_gen.sv
module susp_tick_gen #(
    parameter int TICK_DIV = 6400,
    parameter int MS_TICKS = 31
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic ms_tick
);
    localparam int TW = $clog2(TICK_DIV + 1);
    localparam int MW = $clog2(MS_TICKS + 1);

    typedef struct packed {
        logic [TW-1:0] div;
        logic [MW-1:0] ms;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tick    = (st_q.div == TW'(TICK_DIV - 1));
        ms_tick = tick && (st_q.ms == MW'(MS_TICKS - 1));
        if (tick) st_d.div = '0;
        else      st_d.div = st_q.div + TW'(1);
        if (ms_tick)   st_d.ms = '0;
        else if (tick) st_d.ms = st_q.ms + MW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/susp_regs.sv
module susp_regs
    import susp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output ctrl_t      ctrl
);
    typedef struct packed {
        logic [7:0] idle_cnt;
        logic [7:0] run_cnt;
        logic [7:0] sus_cfg;
        logic [7:0] pm_ctl;
        logic [7:0] irq_cnt;
        logic [7:0] vid_cnt;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            unique case (addr)
                A_IDLE_CNT: rg_d.idle_cnt = wdata;
                A_RUN_CNT:  rg_d.run_cnt  = wdata;
                A_SUS_CFG:  rg_d.sus_cfg  = wdata;
                A_PM_CTL:   rg_d.pm_ctl   = wdata;
                A_IRQ_CNT:  rg_d.irq_cnt  = wdata;
                A_VID_CNT:  rg_d.vid_cnt  = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_IDLE_CNT: rdata = rg_q.idle_cnt;
            A_RUN_CNT:  rdata = rg_q.run_cnt;
            A_SUS_CFG:  rdata = rg_q.sus_cfg;
            A_PM_CTL:   rdata = rg_q.pm_ctl;
            A_IRQ_CNT:  rdata = rg_q.irq_cnt;
            A_VID_CNT:  rdata = rg_q.vid_cnt;
            default:    rdata = 8'h00;
        endcase
    end

    always_comb begin
        ctrl.idle_cnt = rg_q.idle_cnt;
        ctrl.run_cnt  = rg_q.run_cnt;
        ctrl.mod_en   = rg_q.sus_cfg[B_MOD_EN];
        ctrl.gate     = rg_q.pm_ctl[B_GATE];
        ctrl.irq_en   = rg_q.pm_ctl[B_IRQ_EN];
        ctrl.vid_en   = rg_q.pm_ctl[B_VID_EN];
        ctrl.irq_cnt  = rg_q.irq_cnt;
        ctrl.vid_cnt  = rg_q.vid_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) rg_q <= '0;
        else     rg_q <= rg_d;
    end
endmodule

// File: rtl/susp_speedup_timer.sv
module susp_speedup_timer
    import susp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             event_in,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ms_tick,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (event_in && (load_val != '0))
            cnt_d = load_val;
        else if (ms_tick && (cnt_q != '0))
            cnt_d = cnt_q - CNT_W'(1);
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/susp_window_seq.sv
module susp_window_seq
    import susp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] idle_val,
    input  logic [CNT_W-1:0] run_val,
    output logic             susp_n
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] run_lat;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase   = PH_RUN;
            st_d.rem     = '0;
            st_d.run_lat = '0;
        end else if (tick) begin
            if (st_q.rem > CNT_W'(1)) begin
                st_d.rem = st_q.rem - CNT_W'(1);
            end else if (st_q.phase == PH_IDLE && st_q.run_lat != '0) begin
                st_d.phase = PH_RUN;
                st_d.rem   = st_q.run_lat;
            end else begin
                st_d.run_lat = run_val;
                if (idle_val != '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.rem   = idle_val;
                end else begin
                    st_d.phase = PH_RUN;
                    st_d.rem   = run_val;
                end
            end
        end
        susp_n = !(run && st_q.phase == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_RUN, rem: '0, run_lat: '0};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/susp_mod_gen.sv
module susp_mod_gen
    import susp_pkg::*;
#(
    parameter int TICK_DIV = 6400,
    parameter int MS_TICKS = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_event,
    input  logic       video_event,
    output logic       susp_n
);
    ctrl_t             ctrl_w;
    logic              tick_w;
    logic              ms_w;
    logic              run_w;
    logic [N_SPD-1:0]  spd_en;
    logic [N_SPD-1:0]  spd_evt;
    logic [N_SPD-1:0]  spd_busy;
    logic [CNT_W-1:0]  spd_load [N_SPD];

    susp_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl_w)
    );

    susp_tick_gen #(.TICK_DIV(TICK_DIV), .MS_TICKS(MS_TICKS)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .ms_tick (ms_w)
    );

    always_comb begin
        spd_en[SPD_IRQ]   = ctrl_w.irq_en;
        spd_en[SPD_VID]   = ctrl_w.vid_en;
        spd_evt[SPD_IRQ]  = irq_event;
        spd_evt[SPD_VID]  = video_event;
        spd_load[SPD_IRQ] = ctrl_w.irq_cnt;
        spd_load[SPD_VID] = ctrl_w.vid_cnt;
    end

    for (genvar g = 0; g < N_SPD; g++) begin : g_spd
        susp_speedup_timer u_tmr (
            .clk      (clk),
            .rst      (rst),
            .en       (spd_en[g]),
            .event_in (spd_evt[g]),
            .load_val (spd_load[g]),
            .ms_tick  (ms_w),
            .busy     (spd_busy[g])
        );
    end

    assign run_w = ctrl_w.gate && ctrl_w.mod_en && !(|spd_busy);

    susp_window_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (run_w),
        .tick     (tick_w),
        .idle_val (ctrl_w.idle_cnt),
        .run_val  (ctrl_w.run_cnt),
        .susp_n   (susp_n)
    );
endmodule

// File: rtl/susp_mod_chk.sv
module susp_mod_chk
    import susp_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  susp_n,
    input logic  tick,
    input logic  irq_event,
    input logic  video_event,
    input ctrl_t ctrl
);
    // R3: the idle window only opens on a tick
    assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_n) |-> $past(tick));

    // R4: enable bit clear keeps the core running
    assert_disabled_runs_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl.mod_en |-> susp_n);

    // R5: global gate clear keeps the core running
    assert_gate_runs_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl.gate |-> susp_n);

    // R9: an enabled interrupt event releases suspend next cycle
    assert_irq_release_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_event && ctrl.irq_en && ctrl.irq_cnt != '0) |=> susp_n);

    // R10: an enabled video event releases suspend next cycle
    assert_vid_release_R10: assert property (@(posedge clk) disable iff (rst)
        (video_event && ctrl.vid_en && ctrl.vid_cnt != '0) |=> susp_n);
endmodule

bind susp_mod_gen susp_mod_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .susp_n      (susp_n),
    .tick        (tick_w),
    .irq_event   (irq_event),
    .video_event (video_event),
    .ctrl        (ctrl_w)
);

// File: tb/susp_mod_gen_test.sv
module susp_mod_gen_test;
    localparam int TD = 4;
    localparam int MS = 3;
    localparam int MS_CYC = TD * MS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_event = 1'b0;
    logic       video_event = 1'b0;
    logic       susp_n;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        int    lo;
        int    hi;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    susp_mod_gen #(.TICK_DIV(TD), .MS_TICKS(MS)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_event(irq_event),
        .video_event(video_event), .susp_n(susp_n)
    );

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(bit vid);
        if (vid) video_event = 1'b1; else irq_event = 1'b1;
        @(posedge clk);
        @(negedge clk);
        video_event = 1'b0; irq_event = 1'b0;
    endtask

    // counts cycles with susp_n low over n negedges
    task automatic count_low(int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (!susp_n) lows++;
            @(negedge clk);
        end
    endtask

    task automatic wait_fall();
        bit p;
        p = susp_n;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (p && !susp_n) return;
            p = susp_n;
        end
        check("wait_fall timeout", 0, 1);
    endtask

    // driver: program a pair and hand the expected period to the monitor
    task automatic expect_period(int off, int on, string tag);
        exp_t e;
        wr(8'h94, 8'(off));
        wr(8'h95, 8'(on));
        e.lo = off * TD; e.hi = on * TD; e.tag = tag;
        sbq.push_back(e);
        for (int i = 0; i < 6000 && sbq.size() != 0; i++) @(negedge clk);
        if (sbq.size() != 0) begin
            check({tag, " scoreboard drain"}, sbq.size(), 0);
            sbq.delete();
        end
    endtask

    // monitor: measures each low/high pair and compares it with the queue head
    initial begin
        bit prev = 1, have_pair = 0, qual = 0;
        int lo_len = 0, hi_len = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = 1; have_pair = 0; qual = 0;
            end else if (!susp_n) begin
                if (prev) begin
                    if (have_pair && qual && sbq.size() != 0) begin
                        e = sbq.pop_front();
                        check({e.tag, " low length"}, lo_len, e.lo);
                        check({e.tag, " high length"}, hi_len, e.hi);
                    end
                    qual = (sbq.size() != 0);
                    lo_len = 0; hi_len = 0; have_pair = 0;
                end
                lo_len++;
                prev = 0;
            end else begin
                if (!prev) have_pair = 1;
                if (have_pair) hi_len++;
                prev = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int lows, lo, hi;
        logic [7:0] addrs [6] = '{8'h94, 8'h95, 8'h96, 8'h80, 8'h8C, 8'h8D};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 susp_n after reset", int'(susp_n), 1);
        foreach (addrs[i]) begin
            rd(addrs[i], d);
            check("R1 register reset value", int'(d), 0);
        end

        // R2: read-back and unmapped access
        foreach (addrs[i]) wr(addrs[i], 8'(8'h20 + i));
        foreach (addrs[i]) begin
            rd(addrs[i], d);
            check("R2 read-back", int'(d), 8'h20 + i);
        end
        wr(8'h97, 8'hFF);
        rd(8'h97, d);
        check("R2 unmapped reads zero", int'(d), 0);
        rd(8'h94, d);
        check("R2 unmapped write leaves idle count", int'(d), 8'h20);
        wr(8'h8C, 8'h00); wr(8'h8D, 8'h00);

        // R4: enable bit clear, gate set, counts nonzero
        wr(8'h94, 8'd3); wr(8'h95, 8'd3);
        wr(8'h80, 8'h01); wr(8'h96, 8'h00);
        count_low(60, lows);
        check("R4 no suspend while disabled", lows, 0);

        // R3: duty patterns via scoreboard
        wr(8'h96, 8'h01);
        expect_period(3, 5, "R3 pair 3/5");
        expect_period(1, 1, "R3 pair 1/1");
        expect_period(10, 2, "R3 pair 10/2");
        expect_period(255, 1, "R3 pair 255/1");
        expect_period(1, 255, "R3 pair 1/255");

        // R8: mid-period write waits for the boundary
        expect_period(3, 3, "R8 setup 3/3");
        wait_fall();
        wr(8'h94, 8'd6);
        wr(8'h95, 8'd1);
        lo = 2;
        while (!susp_n) begin lo++; @(negedge clk); end
        hi = 0;
        while (susp_n) begin hi++; @(negedge clk); end
        check("R8 current idle window unchanged", lo, 3 * TD);
        check("R8 following run window unchanged", hi, 3 * TD);
        lo = 0;
        while (!susp_n) begin lo++; @(negedge clk); end
        check("R8 next period uses new idle count", lo, 6 * TD);

        // R6: zero idle count
        wr(8'h94, 8'd0); wr(8'h95, 8'd5);
        repeat (40) @(negedge clk);
        count_low(100, lows);
        check("R6 idle count zero never suspends", lows, 0);

        // R7: zero run count
        wr(8'h94, 8'd7); wr(8'h95, 8'd0);
        repeat (60) @(negedge clk);
        count_low(100, lows);
        check("R7 run count zero always suspends", lows, 100);

        // R12: clearing enable releases next cycle
        wr(8'h96, 8'h00);
        check("R12 release after enable cleared", int'(susp_n), 1);
        wr(8'h96, 8'h01);
        repeat (10) @(negedge clk);
        check("R7 suspended again after re-enable", int'(susp_n), 0);

        // R5: gate clear overrides enable
        wr(8'h80, 8'h00);
        check("R12 release after gate cleared", int'(susp_n), 1);
        count_low(60, lows);
        check("R5 gate clear keeps running", lows, 0);

        // R9: interrupt speedup, N = 3
        wr(8'h94, 8'd2); wr(8'h95, 8'd2);
        wr(8'h8C, 8'd3); wr(8'h80, 8'h09);
        repeat (40) @(negedge clk);
        pulse(0);
        count_low(2 * MS_CYC, lows);
        check("R9 released for N-1 ms after irq", lows, 0);
        count_low(24, lows);
        check("R9 throttling resumes after irq timer", int'(lows > 0), 1);

        // R11: reload on repeated event
        repeat (40) @(negedge clk);
        pulse(0);
        count_low(19, lows);
        pulse(0);
        count_low(23, lows);
        check("R11 repeated irq reloads timer", lows, 0);
        repeat (60) @(negedge clk);

        // R9: event ignored with enable clear
        wr(8'h80, 8'h01);
        repeat (20) @(negedge clk);
        pulse(0);
        count_low(20, lows);
        check("R9 irq ignored when its enable is clear", int'(lows > 0), 1);

        // R10: video speedup, N = 2
        wr(8'h8D, 8'd2); wr(8'h80, 8'h11);
        repeat (20) @(negedge clk);
        pulse(1);
        count_low(MS_CYC, lows);
        check("R10 released for N-1 ms after video", lows, 0);
        count_low(24, lows);
        check("R10 throttling resumes after video timer", int'(lows > 0), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule